// File: doc/BRIEF.md
# Dual-Channel Microstep Current Register Block

This block sits between a microprocessor-style write bus and a pair of current-setting channels in a two-phase microstepping motor controller. The bus has an 8-bit data port, an active-low select, a write strobe and two address lines. Each channel keeps three things: a 7-bit magnitude code for an external converter, a direction (sign) bit, and a 3-bit threshold. The threshold sets the current level below which a falling current should decay quickly.

The block runs on a system clock. The asynchronous write strobe passes through a synchronizer, and its rising edge is detected. At that edge the select, address and data inputs are sampled. A write to a channel's magnitude register also updates an active-low fast-decay flag, which is then registered. The flag goes low only when the new code is strictly below both the code it replaces and the channel's threshold. The threshold is compared against the top three magnitude bits.

Top module: `ustep_dac_regs`

## Requirements
- R1: A register loads only on a rising edge of `wr_strobe` when `cs_n` is low. A strobe edge with `cs_n` high changes no output.
- R2: `addr[0]` picks the channel: 0 is channel 0 and 1 is channel 1. A write changes only the selected channel's outputs.
- R3: With `addr[1]` = 0 (magnitude write), `wdata[7]` appears uninverted on the channel's `sign_out` bit and `wdata[6:0]` on its `mag_code`.
- R4: With `addr[1]` = 1 (threshold write), `wdata[6:4]` is stored as the channel's 3-bit threshold. `mag_code` and `sign_out` are left unchanged, and `wdata[7]` and `wdata[3:0]` are ignored.
- R5: After a magnitude write, `decay_n` is 0 only if the new code is strictly less than the previous code and the new code's bits 6..4 are strictly less than the stored threshold. Otherwise it is 1, including when the two codes are equal or the top bits equal the threshold.
- R6: `decay_n` changes only on a magnitude write to its own channel. A threshold write leaves it unchanged.
- R7: The sign bit takes no part in either comparison: only `wdata[6:0]` is compared against the old code.
- R8: A synchronous active-high `rst` clears all magnitudes, signs, thresholds and decay flags to 0, so `decay_n` reads 0 after reset.
- R9: With the default two synchronizer stages, the outputs take the new value at the third rising clock edge after `wr_strobe` rises, and not before. A strobe held high performs one write only, using the data sampled at its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_strobe | input | 1 | Asynchronous write strobe, active on its rising edge |
| addr | input | 2 | Bit 0 selects the channel; bit 1 selects magnitude (0) or threshold (1) |
| wdata | input | 8 | Write data: bit 7 is the sign, bits 6..0 the magnitude, bits 6..4 the threshold |
| mag_code | output | 2x7 | Per-channel magnitude code |
| sign_out | output | 2 | Per-channel direction bit |
| decay_n | output | 2 | Per-channel fast-decay flag, active low |

## Verification
The bench builds the block with its defaults: two channels, 7-bit magnitudes, 3-bit thresholds and a two-stage strobe synchronizer. This fixes the write-to-output latency at three clock edges, so the bench can check the exact cycle in which a write lands. A 3-bit threshold lets the bench reach the extreme values 0 and 7 as well as the equality boundary at 4. The bench also writes codes that differ only in the sign bit, which shows whether the sign leaks into the comparison.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int CH_AW_D     = 1;
    localparam int MAG_W_D     = 7;
    localparam int THR_W_D     = 3;
    localparam int SYNC_N_D    = 2;

    typedef enum logic {
        SEL_MAG = 1'b0,
        SEL_THR = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/ustep_strobe_sync.sv
module ustep_strobe_sync #(
    parameter int STAGES = ustep_pkg::SYNC_N_D
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic strobe_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign strobe_rise = sync_q[STAGES-1] & ~last_q;

    // R9: a held strobe produces a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe_rise |=> !strobe_rise);

endmodule

// File: rtl/ustep_wr_decode.sv
module ustep_wr_decode #(
    parameter int CH_AW  = ustep_pkg::CH_AW_D,
    parameter int DATA_W = ustep_pkg::MAG_W_D + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strobe_rise,
    input  logic                  cs_n,
    input  logic [CH_AW:0]        addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [(2**CH_AW)-1:0] load_mag,
    output logic [(2**CH_AW)-1:0] load_thr,
    output logic [DATA_W-1:0]     bus_data
);
    import ustep_pkg::*;

    localparam int NUM_CH = 2 ** CH_AW;

    logic             take;
    reg_sel_e         sel;
    logic [CH_AW-1:0] ch_idx;

    assign take     = strobe_rise & ~cs_n;
    assign sel      = reg_sel_e'(addr[CH_AW]);
    assign ch_idx   = addr[CH_AW-1:0];
    assign bus_data = wdata;

    always_comb begin
        load_mag = '0;
        load_thr = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (take && (ch_idx == CH_AW'(i))) begin
                load_mag[i] = (sel == SEL_MAG);
                load_thr[i] = (sel == SEL_THR);
            end
        end
    end

    // R2: at most one register of one channel is loaded per write
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_mag, load_thr}));

    // R1: no load without a detected strobe edge under chip select
    a_r1_gated_load: assert property (@(posedge clk) disable iff (rst)
        (!strobe_rise || cs_n) |-> ({load_mag, load_thr} == '0));

endmodule

// File: rtl/ustep_channel.sv
module ustep_channel #(
    parameter int MAG_W = ustep_pkg::MAG_W_D,
    parameter int THR_W = ustep_pkg::THR_W_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_mag,
    input  logic             load_thr,
    input  logic [MAG_W:0]   bus_data,
    output logic [MAG_W-1:0] mag_q,
    output logic             sign_q,
    output logic             decay_nq
);
    localparam int TOP = MAG_W - 1;

    logic [THR_W-1:0] thr_q;
    logic [MAG_W-1:0] new_code;
    logic [THR_W-1:0] new_top;
    logic             below_old;
    logic             below_thr;

    assign new_code  = bus_data[MAG_W-1:0];
    assign new_top   = bus_data[TOP -: THR_W];
    assign below_old = new_code < mag_q;
    assign below_thr = new_top < thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q    <= '0;
            sign_q   <= 1'b0;
            thr_q    <= '0;
            decay_nq <= 1'b0;
        end else begin
            if (load_mag) begin
                mag_q    <= new_code;
                sign_q   <= bus_data[MAG_W];
                decay_nq <= ~(below_old & below_thr);
            end
            if (load_thr) begin
                thr_q <= new_top;
            end
        end
    end

    // R5: flag after a magnitude write agrees with the stored codes
    a_r5_decay_rule: assert property (@(posedge clk) disable iff (rst)
        load_mag |=> (decay_nq == !((mag_q < $past(mag_q)) && (mag_q[TOP -: THR_W] < thr_q))));

    // R6: a threshold write keeps flag, code and sign
    a_r6_thr_keeps: assert property (@(posedge clk) disable iff (rst)
        (load_thr && !load_mag) |=> ($stable(decay_nq) && $stable(mag_q) && $stable(sign_q)));

    // R1: no load means no change at all
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!load_mag && !load_thr) |=> ($stable(mag_q) && $stable(sign_q) && $stable(decay_nq) && $stable(thr_q)));

endmodule

// File: rtl/ustep_dac_regs.sv
module ustep_dac_regs #(
    parameter int CH_AW  = ustep_pkg::CH_AW_D,
    parameter int MAG_W  = ustep_pkg::MAG_W_D,
    parameter int THR_W  = ustep_pkg::THR_W_D,
    parameter int SYNC_N = ustep_pkg::SYNC_N_D,
    localparam int NUM_CH = 2 ** CH_AW,
    localparam int DATA_W = MAG_W + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         wr_strobe,
    input  logic [CH_AW:0]               addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_CH-1:0][MAG_W-1:0] mag_code,
    output logic [NUM_CH-1:0]            sign_out,
    output logic [NUM_CH-1:0]            decay_n
);
    logic              strobe_rise;
    logic [NUM_CH-1:0] load_mag;
    logic [NUM_CH-1:0] load_thr;
    logic [DATA_W-1:0] bus_data;

    ustep_strobe_sync #(.STAGES(SYNC_N)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (wr_strobe),
        .strobe_rise  (strobe_rise)
    );

    ustep_wr_decode #(.CH_AW(CH_AW), .DATA_W(DATA_W)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .strobe_rise (strobe_rise),
        .cs_n        (cs_n),
        .addr        (addr),
        .wdata       (wdata),
        .load_mag    (load_mag),
        .load_thr    (load_thr),
        .bus_data    (bus_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ustep_channel #(.MAG_W(MAG_W), .THR_W(THR_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .load_mag (load_mag[c]),
            .load_thr (load_thr[c]),
            .bus_data (bus_data),
            .mag_q    (mag_code[c]),
            .sign_q   (sign_out[c]),
            .decay_nq (decay_n[c])
        );
    end

    // R8: reset leaves every output cleared
    a_r8_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (mag_code == '0 && sign_out == '0 && decay_n == '0));

endmodule

// File: tb/ustep_dac_regs_tb.sv
module ustep_dac_regs_tb;

    localparam int NCH = 2;

    typedef struct {
        logic [NCH-1:0][6:0] mag;
        logic [NCH-1:0]      sgn;
        logic [NCH-1:0]      dec;
        int                  req;
    } snap_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cs_n = 1'b1;
    logic                wr_strobe = 1'b0;
    logic [1:0]          addr = '0;
    logic [7:0]          wdata = '0;
    logic [NCH-1:0][6:0] mag_code;
    logic [NCH-1:0]      sign_out;
    logic [NCH-1:0]      decay_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NCH-1:0][6:0] m_mag;
    logic [NCH-1:0]      m_sgn;
    logic [NCH-1:0]      m_dec;
    logic [2:0]          m_thr [NCH];

    snap_t q [$];

    always #2.5 clk = ~clk;

    ustep_dac_regs u_dut (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wr_strobe (wr_strobe),
        .addr      (addr),
        .wdata     (wdata),
        .mag_code  (mag_code),
        .sign_out  (sign_out),
        .decay_n   (decay_n)
    );

    task automatic push(input int req);
        snap_t s;
        s.mag = m_mag;
        s.sgn = m_sgn;
        s.dec = m_dec;
        s.req = req;
        q.push_back(s);
    endtask

    task automatic model_reset();
        m_mag = '0;
        m_sgn = '0;
        m_dec = '0;
        for (int i = 0; i < NCH; i++) m_thr[i] = '0;
    endtask

    // model of R3, R4, R5, R7 written from the requirement text
    task automatic model_write(input int ch, input bit thr, input logic [7:0] d);
        if (thr) begin
            m_thr[ch] = d[6:4];
        end else begin
            m_dec[ch] = !((d[6:0] < m_mag[ch]) && (d[6:4] < m_thr[ch]));
            m_mag[ch] = d[6:0];
            m_sgn[ch] = d[7];
        end
    endtask

    task automatic bus_write(input int ch, input bit thr, input logic [7:0] d,
                             input bit sel, input int req);
        @(negedge clk);
        cs_n  = ~sel;
        addr  = {thr, ch[0]};
        wdata = d;
        @(negedge clk);
        wr_strobe = 1'b1;
        repeat (4) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        if (sel) model_write(ch, thr, d);
        push(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        push(8);
    endtask

    task automatic direct_chk(input bit ok, input int req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() != 0) begin
            snap_t e;
            e = q.pop_front();
            checks++;
            if (mag_code !== e.mag || sign_out !== e.sgn || decay_n !== e.dec) begin
                errors++;
                $display("FAIL R%0d: actual mag=%h sign=%b decay_n=%b expected mag=%h sign=%b decay_n=%b",
                         e.req, mag_code, sign_out, decay_n, e.mag, e.sgn, e.dec);
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R8: reset state
        do_reset();
        // R4: threshold 4 on channel 0, other outputs untouched
        bus_write(0, 1'b1, 8'h40, 1'b1, 4);
        // R3: code 0x50, sign 1 on channel 0
        bus_write(0, 1'b0, 8'hD0, 1'b1, 3);
        // R5: 0x30 below old and top 3 < 4 -> fast decay
        bus_write(0, 1'b0, 8'h30, 1'b1, 5);
        // R5: equal code -> slow decay
        bus_write(0, 1'b0, 8'h30, 1'b1, 5);
        bus_write(0, 1'b0, 8'h45, 1'b1, 5);
        // R5: top bits equal threshold -> slow decay
        bus_write(0, 1'b0, 8'h40, 1'b1, 5);
        // R4: threshold 7 on channel 1 with sign and low bits set, ignored; R2
        bus_write(1, 1'b1, 8'hFF, 1'b1, 4);
        bus_write(1, 1'b0, 8'h7F, 1'b1, 2);
        bus_write(1, 1'b0, 8'hE0, 1'b1, 5);
        // R7: 0xDF: magnitude 0x5F below 0x60 despite sign bit
        bus_write(1, 1'b0, 8'hDF, 1'b1, 7);
        // R6: threshold write keeps fast decay flag
        bus_write(1, 1'b1, 8'h00, 1'b1, 6);
        // R5: threshold 0 never yields fast decay
        bus_write(1, 1'b0, 8'h10, 1'b1, 5);
        // R1: strobe with chip select high changes nothing
        bus_write(0, 1'b0, 8'h00, 1'b0, 1);
        bus_write(1, 1'b1, 8'h70, 1'b0, 1);
        bus_write(1, 1'b0, 8'h00, 1'b1, 1);

        // R9: held strobe, data changed while high -> first data only
        @(negedge clk);
        cs_n = 1'b0; addr = 2'b00; wdata = 8'h20;
        @(negedge clk);
        wr_strobe = 1'b1;
        repeat (4) @(negedge clk);
        wdata = 8'h7F;
        repeat (4) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        model_write(0, 1'b0, 8'h20);
        push(9);
        repeat (2) @(negedge clk);

        // R9: latency, new value only at the third edge
        @(negedge clk);
        cs_n = 1'b0; addr = 2'b01; wdata = 8'h05;
        @(negedge clk);
        wr_strobe = 1'b1;
        repeat (2) @(negedge clk);
        direct_chk(mag_code[1] == m_mag[1], 9, int'(mag_code[1]), int'(m_mag[1]));
        @(negedge clk);
        direct_chk(mag_code[1] == 7'h05, 9, int'(mag_code[1]), 5);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        model_write(1, 1'b0, 8'h05);
        push(9);
        repeat (2) @(negedge clk);

        // R8: reset after activity
        do_reset();
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule